// File: doc/BRIEF.md
# Prioritized Interrupt Recognition Unit

This block sits between seven active-low interrupt request lines and a processor core's exception logic. Every line is brought into the clock domain through a synchronizer and then qualified, so that a request only counts once it has been seen asserted on consecutive clock edges. Lines one to six are level-sensitive and can be masked by a three-bit priority mask that the core supplies. Line seven is non-maskable and works on edge plus level: each new assertion raises a level-seven event, which stays pending until the core acknowledges level seven.

Lowering the mask from seven while line seven is still held also raises a fresh level-seven event. The core never sees a request in the middle of an instruction. The block registers its decision, the highest recognized level and a pending flag, only when the core strobes an instruction boundary. An acknowledge from the core drops the pending flag. If the acknowledged level is seven, it also clears the latched non-maskable event.

Top module: `irq_recog_unit`

## Requirements
- R1: A request line is recognized only after it has been sampled low on two consecutive rising clock edges behind the two-flop synchronizer. A low pulse lasting one clock is never reported. A pulse lasting two clocks is reported if a boundary strobe falls in its qualified window.
- R2: Bit i of `irq_n` is request line i+1, and line n has priority n. The reported level is the highest-numbered recognized line that is not masked. Whenever `irq_pend` is 1, `irq_level` is nonzero.
- R3: A line from 1 to 6 whose number is less than or equal to `mask` is ignored. A mask of 0 blocks none of them.
- R4: Each new qualified assertion of line 7 latches a level-7 event whatever the mask value. While that event is pending, a boundary reports level 7 ahead of every other line.
- R5: A change of `mask` from 7 to any lower value while line 7 is qualified low latches a new level-7 event. The same mask change with line 7 released raises nothing.
- R6: The latched level-7 event clears only when `ack` is high with `ack_level` equal to 7. An acknowledge of any other level leaves it pending. Holding line 7 low after it is acknowledged does not raise it again.
- R7: `irq_level` and `irq_pend` are registered. They take a new decision only at a clock edge where `boundary` is high. With no acknowledge, they hold their value between boundaries. A boundary with nothing qualifying gives level 0 with `irq_pend` low.
- R8: An `ack` without `boundary` drops `irq_pend` at the next edge.
- R9: A level 1 to 6 request that is released before it is acknowledged is not reported at a later boundary.
- R10: Synchronous reset clears the outputs to level 0 with `irq_pend` low and discards any pending level-7 event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 7 | Active-low request lines; bit i is line i+1 |
| mask | input | 3 | Priority mask from the core |
| boundary | input | 1 | Instruction-boundary strobe |
| ack | input | 1 | Acknowledge strobe from the core |
| ack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Registered highest recognized level |
| irq_pend | output | 1 | Registered request-pending flag |

## Verification
A corrupted qualifier or synchronizer appears as a request that is reported one boundary too early, or as a one-clock glitch that is reported. Either shows on the first boundary that follows the stimulus. A fault in the priority or mask compare gives a wrong `irq_level` at the very next boundary, so all sixty-four patterns of lines 1 to 6 are swept against every mask value. A stuck or lost level-7 latch shows as level 7 missing, or reappearing, at the first boundary after an assertion, a mask drop or an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Default request-line count and derived level width.
  localparam int IRQ_LINES_DEF = 7;

  function automatic int irq_lvl_width(input int lines);
    return $clog2(lines + 1);
  endfunction
endpackage

// File: rtl/irq_sync_qual.sv
// Synchronizer followed by a qualification window for one request line.
module irq_sync_qual #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic req_ok
);
  logic [SYNC_STAGES-1:0]  sync_sr;
  logic [QUAL_SAMPLES-1:0] qual_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_sr <= '0;
      qual_sr <= '0;
    end else begin
      sync_sr <= {sync_sr[SYNC_STAGES-2:0], ~req_n};
      qual_sr <= {qual_sr[QUAL_SAMPLES-2:0], sync_sr[SYNC_STAGES-1]};
    end
  end

  assign req_ok = &qual_sr;
endmodule

// File: rtl/irq_nmi_latch.sv
// Edge-plus-level detection and pending latch for the top (non-maskable) line.
module irq_nmi_latch #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             top_ok,
  input  logic [LVL_W-1:0] mask,
  input  logic             ack,
  input  logic [LVL_W-1:0] ack_level,
  output logic             nmi_next,
  output logic             nmi_pend
);
  localparam logic [LVL_W-1:0] MAX_LVL = '1;

  logic             top_ok_d;
  logic [LVL_W-1:0] mask_d;
  logic             fresh_edge;
  logic             mask_drop;
  logic             nmi_set;
  logic             nmi_clr;

  assign fresh_edge = top_ok & ~top_ok_d;
  assign mask_drop  = top_ok & (mask_d == MAX_LVL) & (mask != MAX_LVL);
  assign nmi_set    = fresh_edge | mask_drop;
  assign nmi_clr    = ack & (ack_level == MAX_LVL);
  // A new event in the same cycle as a clear wins.
  assign nmi_next   = nmi_set | (nmi_pend & ~nmi_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      top_ok_d <= 1'b0;
      mask_d   <= '0;
      nmi_pend <= 1'b0;
    end else begin
      top_ok_d <= top_ok;
      mask_d   <= mask;
      nmi_pend <= nmi_next;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
// Picks the highest unmasked request; the top level is taken from the NMI latch.
module irq_prio_pick #(
  parameter int NUM_REQ = 7,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_REQ-2:0] lvl_ok,
  input  logic [LVL_W-1:0]   mask,
  input  logic               nmi_hit,
  output logic [LVL_W-1:0]   best_lvl,
  output logic               best_any
);
  logic [NUM_REQ-2:0] unmasked;

  genvar g;
  generate
    for (g = 0; g < NUM_REQ - 1; g++) begin : g_cmp
      assign unmasked[g] = lvl_ok[g] & (LVL_W'(g + 1) > mask);
    end
  endgenerate

  always_comb begin
    best_lvl = '0;
    for (int i = 0; i < NUM_REQ - 1; i++) begin
      if (unmasked[i]) best_lvl = LVL_W'(i + 1);
    end
    if (nmi_hit) best_lvl = LVL_W'(NUM_REQ);
    best_any = nmi_hit | (|unmasked);
  end
endmodule

// File: rtl/irq_recog_unit.sv
module irq_recog_unit
  import irq_pkg::*;
#(
  parameter int NUM_REQ      = IRQ_LINES_DEF,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2,
  localparam int LVL_W       = irq_lvl_width(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] irq_n,
  input  logic [LVL_W-1:0]   mask,
  input  logic               boundary,
  input  logic               ack,
  input  logic [LVL_W-1:0]   ack_level,
  output logic [LVL_W-1:0]   irq_level,
  output logic               irq_pend
);
  logic [NUM_REQ-1:0] req_ok;
  logic               nmi_next;
  logic               nmi_pend;
  logic [LVL_W-1:0]   best_lvl;
  logic               best_any;

  genvar g;
  generate
    for (g = 0; g < NUM_REQ; g++) begin : g_line
      irq_sync_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_SAMPLES(QUAL_SAMPLES)
      ) u_sq (
        .clk   (clk),
        .rst   (rst),
        .req_n (irq_n[g]),
        .req_ok(req_ok[g])
      );
    end
  endgenerate

  irq_nmi_latch #(.LVL_W(LVL_W)) u_nmi (
    .clk      (clk),
    .rst      (rst),
    .top_ok   (req_ok[NUM_REQ-1]),
    .mask     (mask),
    .ack      (ack),
    .ack_level(ack_level),
    .nmi_next (nmi_next),
    .nmi_pend (nmi_pend)
  );

  irq_prio_pick #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_pick (
    .lvl_ok  (req_ok[NUM_REQ-2:0]),
    .mask    (mask),
    .nmi_hit (nmi_next),
    .best_lvl(best_lvl),
    .best_any(best_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      irq_pend  <= 1'b0;
    end else if (boundary) begin
      irq_level <= best_lvl;
      irq_pend  <= best_any;
    end else if (ack) begin
      irq_pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_recog_unit_chk.sv
module irq_recog_unit_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] mask,
  input logic             boundary,
  input logic             ack,
  input logic [LVL_W-1:0] ack_level,
  input logic [LVL_W-1:0] irq_level,
  input logic             irq_pend,
  input logic             nmi_pend
);
  localparam logic [LVL_W-1:0] MAX_LVL = '1;

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq_pend && irq_level == '0));

  // R7
  hold_between_boundaries_chk: assert property (@(posedge clk) disable iff (rst)
    (!boundary && !ack) |=> ($stable(irq_level) && $stable(irq_pend)));

  // R8
  ack_drops_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !boundary) |=> !irq_pend);

  // R2
  pend_has_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> (irq_level != '0));

  // R3
  mask_respected_chk: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (!irq_pend || irq_level == MAX_LVL || irq_level > $past(mask)));

  // R6
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !(ack && ack_level == MAX_LVL)) |=> nmi_pend);

  // R4
  nmi_reported_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && nmi_pend && !(ack && ack_level == MAX_LVL)) |=>
      (irq_pend && irq_level == MAX_LVL));
endmodule

bind irq_recog_unit irq_recog_unit_chk #(.LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mask     (mask),
  .boundary (boundary),
  .ack      (ack),
  .ack_level(ack_level),
  .irq_level(irq_level),
  .irq_pend (irq_pend),
  .nmi_pend (nmi_pend)
);

// File: tb/irq_recog_unit_bench.sv
`timescale 1ns/1ps
module irq_recog_unit_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] irq_n;
  logic [2:0] mask;
  logic       boundary;
  logic       ack;
  logic [2:0] ack_level;
  logic [2:0] irq_level;
  logic       irq_pend;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_recog_unit u_irq_recog_unit (
    .clk(clk), .rst(rst), .irq_n(irq_n), .mask(mask), .boundary(boundary),
    .ack(ack), .ack_level(ack_level), .irq_level(irq_level), .irq_pend(irq_pend)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] lvl_exp, input logic pend_exp);
    checks++;
    if (irq_level !== lvl_exp || irq_pend !== pend_exp) begin
      errors++;
      $display("FAIL %s: level=%0d pend=%0d expected level=%0d pend=%0d",
               req, irq_level, irq_pend, lvl_exp, pend_exp);
    end
  endtask

  // One-cycle boundary strobe; outputs checked on the next falling edge.
  task automatic strobe_boundary();
    boundary = 1'b1;
    tick(1);
    boundary = 1'b0;
  endtask

  task automatic pulse_ack(input logic [2:0] lvl);
    ack = 1'b1;
    ack_level = lvl;
    tick(1);
    ack = 1'b0;
  endtask

  function automatic logic [2:0] expect_lvl(input logic [5:0] act, input int m);
    logic [2:0] r = 3'd0;
    for (int i = 1; i <= 6; i++) if (act[i-1] && i > m) r = 3'(i);
    return r;
  endfunction

  initial begin
    irq_n = 7'h7F; mask = 3'd0; boundary = 1'b0; ack = 1'b0; ack_level = 3'd0;
    rst = 1'b1;
    tick(3);
    check("R10 reset", 3'd0, 1'b0);
    rst = 1'b0;
    tick(6);
    strobe_boundary();
    check("R7 empty boundary", 3'd0, 1'b0);

    // R2 R3: all patterns of lines 1..6 against every mask.
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 64; p++) begin
        logic [2:0] e;
        mask  = 3'(m);
        irq_n = {1'b1, ~6'(p)};
        tick(5);
        strobe_boundary();
        e = expect_lvl(6'(p), m);
        check("R2 R3 sweep", e, e != 3'd0);
      end
    end
    irq_n = 7'h7F; mask = 3'd0;
    tick(6);

    // R1: one-cycle glitch on line 4 never reported.
    boundary = 1'b1;
    irq_n[3] = 1'b0;
    tick(1);
    irq_n[3] = 1'b1;
    for (int i = 0; i < 7; i++) begin
      tick(1);
      check("R1 one-cycle glitch", 3'd0, 1'b0);
    end
    boundary = 1'b0;
    tick(2);

    // R1: two-cycle pulse on line 4, boundary at its qualified window.
    irq_n[3] = 1'b0;
    tick(2);
    irq_n[3] = 1'b1;
    tick(2);
    strobe_boundary();
    check("R1 two-cycle pulse", 3'd4, 1'b1);
    tick(5);
    strobe_boundary();
    check("R9 released request", 3'd0, 1'b0);

    // R4: new assertion of line 7 under a full mask.
    mask = 3'd7;
    irq_n[6] = 1'b0;
    tick(6);
    strobe_boundary();
    check("R4 nmi under mask 7", 3'd7, 1'b1);

    // R8 and R6: acknowledge of another level.
    pulse_ack(3'd5);
    check("R8 ack drops pend", 3'd7, 1'b0);
    strobe_boundary();
    check("R6 other-level ack keeps nmi", 3'd7, 1'b1);

    // R6: acknowledge 7, line still held: no re-raise.
    pulse_ack(3'd7);
    tick(3);
    strobe_boundary();
    check("R6 held line no re-raise", 3'd0, 1'b0);

    // R5: mask drop from 7 while held.
    mask = 3'd3;
    tick(2);
    strobe_boundary();
    check("R5 mask drop retrigger", 3'd7, 1'b1);
    pulse_ack(3'd7);
    strobe_boundary();
    check("R6 cleared after ack 7", 3'd0, 1'b0);
    mask = 3'd7; tick(2);
    mask = 3'd0; tick(2);
    strobe_boundary();
    check("R5 second mask drop", 3'd7, 1'b1);
    pulse_ack(3'd7);

    // R5: mask drop with line 7 released raises nothing.
    irq_n[6] = 1'b1;
    tick(6);
    mask = 3'd7; tick(2);
    mask = 3'd0; tick(2);
    strobe_boundary();
    check("R5 mask drop without line 7", 3'd0, 1'b0);

    // R4: new assertion beats lower lines.
    irq_n[2] = 1'b0;
    irq_n[6] = 1'b0;
    tick(6);
    strobe_boundary();
    check("R4 nmi beats line 3", 3'd7, 1'b1);
    pulse_ack(3'd7);
    strobe_boundary();
    check("R2 line 3 after nmi ack", 3'd3, 1'b1);
    irq_n = 7'h7F;
    pulse_ack(3'd3);

    // R7: output holds without a boundary.
    irq_n[4] = 1'b0;
    tick(8);
    check("R7 hold without boundary", 3'd3, 1'b0);
    strobe_boundary();
    check("R7 update at boundary", 3'd5, 1'b1);
    irq_n[4] = 1'b1;
    tick(6);
    check("R7 hold after release", 3'd5, 1'b1);
    strobe_boundary();
    check("R9 withdrawn before ack", 3'd0, 1'b0);

    // R10: reset discards a pending nmi.
    irq_n[6] = 1'b0;
    tick(6);
    irq_n[6] = 1'b1;
    rst = 1'b1; tick(2); rst = 1'b0;
    tick(6);
    strobe_boundary();
    check("R10 reset clears nmi", 3'd0, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: level=%0d pend=%0d expected completion", irq_level, irq_pend);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule